// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block is the interrupt half of a 32-line general-purpose I/O bank. Each line arrives already synchronized to the block clock. Each line carries its own 3-bit event kind, which picks one of five trigger conditions: a low-to-high transition, a high-to-low transition, either transition, a held low level or a held high level. A detected event latches into a per-line status bit. Software collects the latched bits by reading the status word, and that read also clears them. A per-line mask decides which latched bits may raise the single bank interrupt.

Software changes the mask only through two write-one registers: one that turns lines on and one that turns lines off. The mask itself can be read but not written. A service routine reads status, ANDs the result with the mask, handles the lines it finds, and repeats until the masked value is zero. An event that arrives during a read is therefore held over for the next read. The register port is a plain single-cycle strobe interface with no back-pressure. Read data appears on `rd_data` in the cycle after the read strobe and is zero in every other cycle.

Top module: `gpio_evt_bank`

## Requirements
- R1: With event kind 1, a line that is low in one sampled cycle and high in the next sets its status bit.
- R2: With event kind 0, a high-then-low sample pair sets the status bit, and a rise does not.
- R3: With event kind 2, both a rise and a fall set the status bit.
- R4: With event kind 3 (low) or 4 (high), the status bit is set again on every cycle the level holds, so it reappears after a clearing read.
- R5: Event kinds 5, 6 and 7 never set a status bit, whatever the line does.
- R6: A read at offset 0x2C returns the status word in the next cycle and clears every bit that was returned.
- R7: An event detected in the same cycle as a status read is kept in status and shows up in the following read.
- R8: A write at offset 0x20 sets the mask bits where the written data is 1 and leaves the other mask bits unchanged.
- R9: A write at offset 0x24 clears the mask bits where the written data is 1 and leaves the other mask bits unchanged.
- R10: A read at offset 0x28 returns the mask. Writes to offsets 0x28 and 0x2C change neither the mask nor the status.
- R11: Status bits latch whether or not the line is masked. The mask only gates the interrupt.
- R12: `irq` is a register that is high one cycle after any bit is set in both status and mask, and low one cycle after no such bit remains.
- R13: After reset, status, mask, `irq` and `rd_data` are all zero. Every line's previous sample is taken as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lvl | input | 32 | Synchronized line levels |
| evt_kind | input | 96 | 3-bit event kind per line; line i uses bits [3i+2:3i] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Write data, one bit per line |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Bank interrupt |

## Verification
The bench targets the following corner cases. Each is listed with the fault it exposes.

- **Event on the read edge.** A line edge lands on the same clock edge as a status read. A design that applies the clear after the set loses that event, so the next read comes back empty.
- **Level events after a read.** Level events are read back-to-back. A design that treats levels as edges returns zero on the second read.
- **Reserved event kinds.** Lines set to kinds 5 to 7 are toggled. A design that decodes only part of the select bits reports false events.
- **Masked lines.** A masked line fires. A design that gates latching by the mask shows an empty status.
- **Mask writes.** Enable and disable writes use sparse data. A design that copies the written word instead of merging it corrupts neighbouring mask bits.

The interrupt output is also checked across each set and clear, to catch an off-by-one-cycle fault.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [2:0] {
    EVT_FALL = 3'd0,
    EVT_RISE = 3'd1,
    EVT_BOTH = 3'd2,
    EVT_LOW  = 3'd3,
    EVT_HIGH = 3'd4
  } evt_kind_e;

  localparam logic [7:0] OFS_SET  = 8'h20;
  localparam logic [7:0] OFS_CLR  = 8'h24;
  localparam logic [7:0] OFS_MASK = 8'h28;
  localparam logic [7:0] OFS_STAT = 8'h2C;

  typedef struct packed {
    logic set_wr;
    logic clr_wr;
    logic ro_wr;
    logic mask_rd;
    logic stat_rd;
  } reg_access_t;

endpackage

// File: rtl/gpio_evt_line.sv
module gpio_evt_line
  import gpio_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [2:0] kind,
  output logic       hit
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    case (kind)
      EVT_FALL: hit = prev_q & ~lvl;
      EVT_RISE: hit = ~prev_q & lvl;
      EVT_BOTH: hit = prev_q ^ lvl;
      EVT_LOW:  hit = ~lvl;
      EVT_HIGH: hit = lvl;
      default:  hit = 1'b0;
    endcase
  end

  // R5: reserved kinds stay silent
  p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind > 3'd4) |-> !hit);

endmodule

// File: rtl/gpio_evt_decode.sv
module gpio_evt_decode
  import gpio_evt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output reg_access_t       acc
);

  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  always_comb begin
    acc.set_wr  = wr_en && (addr == A_SET);
    acc.clr_wr  = wr_en && (addr == A_CLR);
    acc.ro_wr   = wr_en && ((addr == A_MASK) || (addr == A_STAT));
    acc.mask_rd = rd_en && (addr == A_MASK);
    acc.stat_rd = rd_en && (addr == A_STAT);
  end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] hit,
  input  reg_access_t       acc,
  input  logic [NLINES-1:0] wr_data,
  output logic [NLINES-1:0] status,
  output logic [NLINES-1:0] mask
);

  logic [NLINES-1:0] stat_kept;

  // clear applies first, new events land on top (R7)
  assign stat_kept = acc.stat_rd ? '0 : status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= stat_kept | hit;
      if (acc.set_wr)      mask <= mask | wr_data;
      else if (acc.clr_wr) mask <= mask & ~wr_data;
    end
  end

  // R8: enable write turns on every written one
  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc.set_wr |=> ((mask & $past(wr_data)) == $past(wr_data)));

  // R9: disable write turns off every written one
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc.clr_wr |=> ((mask & $past(wr_data)) == '0));

  // R7: no status bit is lost without a status read
  p_stat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc.stat_rd |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int KIND_W = 3,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINES-1:0]        line_lvl,
  input  logic [NLINES*KIND_W-1:0] evt_kind,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NLINES-1:0]        wr_data,
  output logic [NLINES-1:0]        rd_data,
  output logic                     irq
);

  logic [NLINES-1:0] hit;
  logic [NLINES-1:0] status;
  logic [NLINES-1:0] mask;
  reg_access_t       acc;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    gpio_evt_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (line_lvl[g]),
      .kind  (evt_kind[g*KIND_W +: 3]),
      .hit   (hit[g])
    );
  end

  gpio_evt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .acc   (acc)
  );

  gpio_evt_regs #(.NLINES(NLINES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .acc     (acc),
    .wr_data (wr_data),
    .status  (status),
    .mask    (mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= |(status & mask);
      if (acc.stat_rd)      rd_data <= status;
      else if (acc.mask_rd) rd_data <= mask;
      else                  rd_data <= '0;
    end
  end

  // R6: status read returns the pre-clear word
  p_stat_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc.stat_rd |=> (rd_data == $past(status)));

  // R10: writes to read-only offsets leave the mask alone
  p_mask_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc.ro_wr |=> $stable(mask));

  // R12: interrupt rises only after a pending unmasked bit
  p_irq_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((status & mask) != '0));

  // R12: interrupt falls only once nothing unmasked is pending
  p_irq_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past((status & mask) == '0));

endmodule

// File: tb/gpio_evt_bank_tb.sv
module gpio_evt_bank_tb;

  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] line_lvl = '0;
  logic [NL*3-1:0] evt_kind = '1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [NL-1:0] wr_data = '0;
  logic [NL-1:0] rd_data;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  gpio_evt_bank u_dut (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .evt_kind(evt_kind),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  always #4 clk = ~clk;

  // reference model built from the requirements
  logic [NL-1:0] m_prev, m_stat, m_mask;
  logic          m_irq;
  logic          rd_pend;
  logic [NL-1:0] exp_q[$];
  string         tag_q[$];
  string         cur_tag = "R13";

  function automatic logic ev(logic [2:0] k, logic p, logic l);
    case (k)
      3'd0: return p & ~l;
      3'd1: return ~p & l;
      3'd2: return p ^ l;
      3'd3: return ~l;
      3'd4: return l;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_stat = '0; m_mask = '0; m_irq = 1'b0; rd_pend = 1'b0;
    end else begin
      logic [NL-1:0] h;
      logic [NL-1:0] s;
      logic          ni;
      for (int i = 0; i < NL; i++) h[i] = ev(evt_kind[i*3 +: 3], m_prev[i], line_lvl[i]);
      rd_pend = rd_en;
      if (rd_en) begin
        exp_q.push_back(addr == 8'h2C ? m_stat : (addr == 8'h28 ? m_mask : '0));
        tag_q.push_back(cur_tag);
      end
      ni = |(m_stat & m_mask);
      s  = (rd_en && addr == 8'h2C) ? '0 : m_stat;
      m_stat = s | h;
      if (wr_en && addr == 8'h20) m_mask = m_mask | wr_data;
      if (wr_en && addr == 8'h24) m_mask = m_mask & ~wr_data;
      m_prev = line_lvl;
      m_irq  = ni;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [NL-1:0] act,
                     input logic [NL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_pend) begin
      if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", rd_data, '0);
      else begin
        logic [NL-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
      rd_pend = 1'b0;
    end
  end

  task automatic chk_irq(input string tag);
    @(negedge clk);
    chk(irq === m_irq, tag, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [NL-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    cur_tag = tag; rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_kind(input int i, input logic [2:0] k);
    @(negedge clk);
    evt_kind[i*3 +: 3] = k;
  endtask

  task automatic set_line(input int i, input logic v);
    @(negedge clk);
    line_lvl[i] = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0, "R13 irq", {31'd0, irq}, '0);
    chk(rd_data === '0, "R13 rd_data", rd_data, '0);
    bus_rd(8'h28, "R13 mask");
    bus_rd(8'h2C, "R13 status");

    bus_wr(8'h20, 32'h0000_00FF);
    bus_rd(8'h28, "R8 mask set");
    bus_wr(8'h20, 32'h0000_0100);
    bus_rd(8'h28, "R8 mask merge");
    bus_wr(8'h24, 32'h0000_000F);
    bus_rd(8'h28, "R9 mask clear");
    bus_wr(8'h28, 32'hFFFF_FFFF);
    bus_rd(8'h28, "R10 mask ro");
    bus_wr(8'h2C, 32'hFFFF_FFFF);
    bus_rd(8'h2C, "R10 status ro");

    set_kind(4, 3'd1);
    set_line(4, 1'b1);
    chk_irq("R12 irq lag");
    chk_irq("R12 irq set");
    bus_rd(8'h2C, "R1 rise");
    bus_rd(8'h2C, "R6 cleared");
    chk_irq("R12 irq clear");

    set_kind(5, 3'd0);
    set_line(5, 1'b1);
    bus_rd(8'h2C, "R2 no rise");
    set_line(5, 1'b0);
    bus_rd(8'h2C, "R2 fall");

    set_kind(6, 3'd2);
    set_line(6, 1'b1);
    bus_rd(8'h2C, "R3 rise");
    set_line(6, 1'b0);
    bus_rd(8'h2C, "R3 fall");

    set_kind(7, 3'd4);
    set_line(7, 1'b1);
    bus_rd(8'h2C, "R4 high");
    bus_rd(8'h2C, "R4 high again");
    set_kind(7, 3'd7);
    set_kind(8, 3'd3);
    bus_rd(8'h2C, "R4 low");
    bus_rd(8'h2C, "R4 low again");
    set_kind(8, 3'd7);
    bus_rd(8'h2C, "R4 drain");
    bus_rd(8'h2C, "R4 idle");

    set_kind(9, 3'd5); set_kind(10, 3'd6); set_kind(11, 3'd7);
    set_line(9, 1'b1); set_line(10, 1'b1); set_line(11, 1'b1);
    set_line(9, 1'b0); set_line(10, 1'b0); set_line(11, 1'b0);
    bus_rd(8'h2C, "R5 reserved");

    set_kind(12, 3'd1);
    @(negedge clk);
    cur_tag = "R7 same-cycle read"; rd_en = 1'b1; addr = 8'h2C; line_lvl[12] = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    bus_rd(8'h2C, "R7 event kept");

    set_kind(20, 3'd1);
    set_line(20, 1'b1);
    chk_irq("R11 masked no irq");
    chk_irq("R11 masked no irq later");
    bus_wr(8'h20, 32'h0010_0000);
    chk_irq("R12 irq after enable");
    chk_irq("R12 irq after enable 2");
    bus_rd(8'h2C, "R11 latched while masked");
    chk_irq("R12 irq drop");
    chk_irq("R12 irq low");

    idle(4);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), '0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule